// File: doc/BRIEF.md
# Flash Status Bit Generator

This block forms the word a NOR flash presents on reads while an internal program or erase job is under way. The job itself is timed elsewhere. This block is told when a job starts, whether it is an erase, which address and data bit 7 were loaded, when the job is busy and when it has failed. From that it decides, read by read, whether the bus carries true array data or a status word. The status word has a polling bit, a toggling bit and a failure bit. It also drives a ready/busy line.

A two-bit poll configuration sets the meaning of bit 7. In value 00 it is a data-complement poll during programming and a constant low during erase. In value 01 it is a plain done flag. A failure is sticky: status reads continue after the engine goes idle, until an exit command is written. During a program job, only the address that was loaded shows status. Reads of any other address pass array data through.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, the poll configuration is 00, the failure flag is clear, `rdy_busy` is 1 and reads return `array_data` unchanged.
- R2: A configuration write with value 00 or 01 takes effect from the next cycle. A write with 10 or 11 is ignored and the previous setting stays.
- R3: In setting 00, a read of the loaded address during a program job returns the inverse of the loaded bit 7 on bit 7. The status word is bit 7 poll, bit 6 toggle, bit 5 failure, and every other bit is 0.
- R4: During a program job, a read of any address other than the loaded one returns `array_data` and does not advance the toggle bit.
- R5: In setting 00, every read during an erase job returns 0 on bit 7.
- R6: In setting 01, status bit 7 is 0 while `op_busy` is high. It is 1 when status is shown with the engine idle, which is the failed state.
- R7: Bit 6 reads 0 on the first status read after `op_start`. It inverts on each later status read.
- R8: Bit 5 is 0 while a job runs without failure. An `op_fail` pulse sets it to 1 from the next cycle.
- R9: Once bit 5 is set, status reads continue after `op_busy` falls, until `exit_cmd` is pulsed. From the cycle after that pulse, reads return array data.
- R10: When the engine is idle and no failure is held, reads return true array data on all bits and the toggle bit stops advancing.
- R11: `rdy_busy` equals the inverse of `op_busy` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse at the start of a job; captures the job context |
| op_is_erase | input | 1 | Job kind at `op_start`: 1 erase, 0 program |
| load_addr | input | AW | Address loaded for the job |
| load_d7 | input | 1 | Bit 7 of the data word loaded for the job |
| op_busy | input | 1 | Engine busy flag |
| op_fail | input | 1 | Pulse: pulse limit exceeded or protected target |
| exit_cmd | input | 1 | Pulse: identification-exit command, clears the failure |
| cfg_wr | input | 1 | Poll configuration write strobe |
| cfg_val | input | 2 | Poll configuration value |
| rd_strobe | input | 1 | One-cycle read strobe |
| rd_addr | input | AW | Read address |
| array_data | input | DW | True array contents at `rd_addr` |
| rd_data | output | DW | Read data: array data or status word |
| stat_active | output | 1 | 1 when `rd_data` carries status |
| rdy_busy | output | 1 | Ready/busy line, low while busy |

## Verification
`rd_data` and `stat_active` depend combinationally on the current inputs and on registered context. The bench therefore samples them in the same cycle as the read strobe, one nanosecond after it drives inputs on the falling edge. Every other result takes one register: the context captured at `op_start`, a configuration write, the failure set by `op_fail` or cleared by `exit_cmd`, the toggle advance and `rdy_busy`. The bench updates its model only after the rising edge that stores these. Its checks after that edge therefore see the new state, and any read in the same cycle is compared with the old state.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        POLL_INVERT = 2'b00,
        POLL_DONE   = 2'b01
    } poll_mode_e;

    typedef struct packed {
        logic is_erase;
        logic ld_bit7;
    } op_ctx_t;

    localparam int STAT_W = 8;

    function automatic logic cfg_legal(input logic [1:0] v);
        return (v == 2'b00) || (v == 2'b01);
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input logic b7,
                                                      input logic b6,
                                                      input logic b5);
        logic [STAT_W-1:0] s;
        s    = '0;
        s[7] = b7;
        s[6] = b6;
        s[5] = b5;
        return s;
    endfunction

endpackage

// File: rtl/fsg_cfg_reg.sv
module fsg_cfg_reg
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    output poll_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= POLL_INVERT;
        end else if (wr_en && cfg_legal(wr_val)) begin
            mode <= poll_mode_e'(wr_val);
        end
    end
endmodule

// File: rtl/fsg_op_track.sv
module fsg_op_track
    import fsg_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_start,
    input  logic          op_is_erase,
    input  logic [AW-1:0] load_addr,
    input  logic          load_d7,
    input  logic          op_busy,
    input  logic          op_fail,
    input  logic          exit_cmd,
    output op_ctx_t       ctx,
    output logic [AW-1:0] ld_addr,
    output logic          fail_q,
    output logic          rdy_busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx     <= '0;
            ld_addr <= '0;
        end else if (op_start) begin
            ctx.is_erase <= op_is_erase;
            ctx.ld_bit7  <= load_d7;
            ld_addr      <= load_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
        end else if (op_fail) begin
            fail_q <= 1'b1;
        end else if (exit_cmd) begin
            fail_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_busy <= 1'b1;
        end else begin
            rdy_busy <= ~op_busy;
        end
    end
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic tog
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tog <= 1'b0;
        end else if (adv) begin
            tog <= ~tog;
        end
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_start,
    input  logic          op_is_erase,
    input  logic [AW-1:0] load_addr,
    input  logic          load_d7,
    input  logic          op_busy,
    input  logic          op_fail,
    input  logic          exit_cmd,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_val,
    input  logic          rd_strobe,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data,
    output logic          stat_active,
    output logic          rdy_busy
);
    localparam int PAD_W = DW - STAT_W;

    poll_mode_e      mode_e;
    logic [1:0]      mode_q;
    op_ctx_t         ctx_q;
    logic [AW-1:0]   ld_addr_q;
    logic            fail_q;
    logic            tog_q;
    logic            in_status;
    logic            addr_hit;
    logic            poll_bit;
    logic [STAT_W-1:0] stat_word;

    fsg_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr),
        .wr_val (cfg_val),
        .mode   (mode_e)
    );

    fsg_op_track #(.AW(AW)) u_track (
        .clk         (clk),
        .rst         (rst),
        .op_start    (op_start),
        .op_is_erase (op_is_erase),
        .load_addr   (load_addr),
        .load_d7     (load_d7),
        .op_busy     (op_busy),
        .op_fail     (op_fail),
        .exit_cmd    (exit_cmd),
        .ctx         (ctx_q),
        .ld_addr     (ld_addr_q),
        .fail_q      (fail_q),
        .rdy_busy    (rdy_busy)
    );

    fsg_toggle u_tog (
        .clk (clk),
        .rst (rst),
        .clr (op_start),
        .adv (rd_strobe && stat_active),
        .tog (tog_q)
    );

    assign mode_q = mode_e;

    always_comb begin
        in_status   = op_busy || fail_q;
        addr_hit    = (rd_addr == ld_addr_q);
        stat_active = in_status && (ctx_q.is_erase || addr_hit);
        if (mode_e == POLL_DONE) begin
            poll_bit = ~op_busy;
        end else if (ctx_q.is_erase) begin
            poll_bit = 1'b0;
        end else begin
            poll_bit = ~ctx_q.ld_bit7;
        end
        stat_word = pack_status(poll_bit, tog_q, fail_q);
        if (stat_active) begin
            rd_data = {{PAD_W{1'b0}}, stat_word};
        end else begin
            rd_data = array_data;
        end
    end
endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          op_busy,
    input logic          op_start,
    input logic          op_fail,
    input logic          exit_cmd,
    input logic          rd_strobe,
    input logic          rdy_busy,
    input logic          stat_active,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] array_data,
    input logic          fail_q,
    input logic          tog_q,
    input logic [1:0]    mode_q,
    input logic          is_erase
);
    AST_RDY_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rdy_busy == !$past(op_busy))); // R11
    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (rst)
        (stat_active && is_erase && mode_q == 2'b00) |-> !rd_data[7]); // R5
    AST_TOGGLE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && stat_active && !op_start) |=> (tog_q != $past(tog_q))); // R7
    AST_TOGGLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !tog_q); // R7
    AST_FAIL_SETS: assert property (@(posedge clk) disable iff (rst)
        op_fail |=> fail_q); // R8
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail_q && !exit_cmd) |=> fail_q); // R9
    AST_NO_FAIL_BIT: assert property (@(posedge clk) disable iff (rst)
        (stat_active && !fail_q) |-> !rd_data[5]); // R8
    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (!op_busy && !fail_q) |-> (!stat_active && rd_data == array_data)); // R10
    AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
        !mode_q[1]); // R2
endmodule

bind flash_status_gen fsg_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_busy     (op_busy),
    .op_start    (op_start),
    .op_fail     (op_fail),
    .exit_cmd    (exit_cmd),
    .rd_strobe   (rd_strobe),
    .rdy_busy    (rdy_busy),
    .stat_active (stat_active),
    .rd_data     (rd_data),
    .array_data  (array_data),
    .fail_q      (fail_q),
    .tog_q       (tog_q),
    .mode_q      (mode_q),
    .is_erase    (ctx_q.is_erase)
);

// File: tb/flash_status_gen_tb_top.sv
`timescale 1ns/1ps
module flash_status_gen_tb_top;
    localparam int DW = 16;
    localparam int AW = 19;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic op_start = 0, op_is_erase = 0, load_d7 = 0, op_busy = 0;
    logic op_fail = 0, exit_cmd = 0, cfg_wr = 0, rd_strobe = 0;
    logic [1:0] cfg_val = '0;
    logic [AW-1:0] load_addr = '0, rd_addr = '0;
    logic [DW-1:0] array_data = '0, rd_data;
    logic stat_active, rdy_busy;

    flash_status_gen #(.DW(DW), .AW(AW)) dut_i (.*);

    int checks = 0, failures = 0;
    bit done = 0;

    logic [1:0] m_mode = 2'b00;
    logic m_busy = 0, m_fail = 0, m_tog = 0, m_erase = 0, m_d7 = 0;
    logic [AW-1:0] m_addr = '0;

    function automatic logic exp_shown(input logic [AW-1:0] a);
        return (m_busy || m_fail) && (m_erase || a == m_addr);
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a,
                                               input logic [DW-1:0] arr);
        logic [DW-1:0] r;
        if (!exp_shown(a)) return arr;
        r = '0;
        r[7] = (m_mode == 2'b01) ? !m_busy : (m_erase ? 1'b0 : !m_d7);
        r[6] = m_tog;
        r[5] = m_fail;
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_rdy();
        check("R11 rdy_busy", DW'(rdy_busy), DW'(!m_busy));
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] arr,
                           input string req);
        logic sh;
        rd_strobe = 1; rd_addr = a; array_data = arr;
        #1;
        sh = exp_shown(a);
        check(req, rd_data, exp_read(a, arr));
        check({req, " stat_active"}, DW'(stat_active), DW'(sh));
        tick();
        rd_strobe = 0;
        if (sh) m_tog = !m_tog;
    endtask

    task automatic start_op(input logic er, input logic d7, input logic [AW-1:0] a);
        op_start = 1; op_busy = 1; op_is_erase = er; load_d7 = d7; load_addr = a;
        tick();
        op_start = 0;
        m_busy = 1; m_tog = 0; m_erase = er; m_d7 = d7; m_addr = a;
        check_rdy();
    endtask

    task automatic end_op();
        op_busy = 0;
        tick();
        m_busy = 0;
        check_rdy();
    endtask

    task automatic fail_pulse();
        op_fail = 1;
        tick();
        op_fail = 0;
        m_fail = 1;
    endtask

    task automatic do_exit();
        exit_cmd = 1;
        tick();
        exit_cmd = 0;
        m_fail = 0;
    endtask

    task automatic cfg(input logic [1:0] v);
        cfg_wr = 1; cfg_val = v;
        tick();
        cfg_wr = 0;
        if (!v[1]) m_mode = v;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) tick();
        rst = 0;
        tick();
        // R1: reset state
        check("R1 rdy_busy", DW'(rdy_busy), DW'(1));
        do_read(19'h00005, 16'hA5C3, "R1 passthru");

        // R2: illegal value ignored, bit 7 must still invert (setting 00)
        cfg(2'b10);
        start_op(1'b0, 1'b1, 19'h00123);
        do_read(19'h00123, 16'hFFFF, "R2 R3 invert poll");
        do_read(19'h00123, 16'hFFFF, "R7 toggle second");
        do_read(19'h00124, 16'h1357, "R4 other addr");
        do_read(19'h00123, 16'h0000, "R4 R7 no advance");
        end_op();
        do_read(19'h00123, 16'hBEEF, "R10 done data");

        // R6 with erase in setting 01
        cfg(2'b01);
        start_op(1'b1, 1'b1, 19'h40000);
        do_read(19'h12345, 16'hFFFF, "R6 busy low");
        cfg(2'b00);
        do_read(19'h00001, 16'hFFFF, "R5 erase poll");
        fail_pulse();
        do_read(19'h00002, 16'hFFFF, "R8 fail bit");
        end_op();
        do_read(19'h00003, 16'hFFFF, "R9 sticky");
        cfg(2'b01);
        do_read(19'h00004, 16'h0000, "R6 idle high");
        do_exit();
        do_read(19'h00004, 16'h7E7E, "R9 after exit");
        cfg(2'b00);

        // random phase
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (!m_busy && !m_fail) begin
                if (r < 3)
                    start_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                             AW'($urandom_range(0, 63)));
                else if (r < 5)
                    cfg(2'($urandom_range(0, 3)));
                else
                    do_read(AW'($urandom_range(0, 63)), DW'($urandom), "R10 R1 idle read");
            end else if (m_busy) begin
                if (r == 0) fail_pulse();
                else if (r == 1) end_op();
                else if (r == 2) cfg(2'($urandom_range(0, 3)));
                else if (r < 6) do_read(m_addr, DW'($urandom), "R3 R5 R6 R7 busy read");
                else do_read(AW'($urandom_range(0, 63)), DW'($urandom), "R4 R5 busy read");
            end else begin
                if (r < 3) do_exit();
                else do_read(AW'($urandom_range(0, 63)), DW'($urandom), "R9 R8 failed read");
            end
        end
        if (m_busy) end_op();
        if (m_fail) do_exit();
        do_read(19'h00010, 16'h55AA, "R10 final");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule